// File: doc/BRIEF.md
# Zero-Page Bit Manipulation Unit

This execution unit performs single-bit and accumulator-masked bit operations on one byte fetched from memory. Each cycle it decodes an 8-bit opcode and produces, one clock later, the byte to write back with its write strobe, the negative, overflow and zero flag values with one enable each, and a branch decision with a 16-bit target. The surrounding processor fetches the operand byte and the displacement, supplies the accumulator and the address of the current opcode, and performs the memory write and flag update that the unit requests.

Four families are handled. Single-bit clear and set rewrite one bit of the operand. Bit-test branches examine one bit and branch relative to the next instruction when it matches the polarity the opcode names. Masked test-and-set and test-and-clear merge the accumulator into the operand and report flags from the merged byte. All other opcodes leave the unit idle.

Top module: `zbit_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every output is zero after that edge.
- R2: Outputs are registered: they reflect the inputs sampled at the previous rising edge with `rst_n` high.
- R3: Opcode with low nibble 0x7 and high nibble i in 0..7 asserts `wr_en_o` with `wr_data_o` = operand with bit i cleared; no flag enable and no branch.
- R4: Opcode with low nibble 0x7 and high nibble 8+i asserts `wr_en_o` with `wr_data_o` = operand with bit i set; no flag enable and no branch.
- R5: Opcode with low nibble 0xF and high nibble i in 0..7 branches when operand bit i is 0; high nibble 8+i branches when bit i is 1. These never write and enable no flag.
- R6: A taken bit branch gives `br_target_o` = pc + 3 + sign-extended displacement, modulo 2^16.
- R7: A bit branch that is not taken gives `br_target_o` = pc + 3.
- R8: Opcodes 0x14 and 0x1C write operand AND NOT accumulator; opcodes 0x04 and 0x0C write operand OR accumulator.
- R9: For the four opcodes of R8, all three flag enables are high, `n_o` = result bit 7, `v_o` = result bit 6, `z_o` = 1 exactly when the result is 0x00.
- R10: Any other opcode gives no write, no flag enable, no branch and `br_target_o` = 0; only bit branches drive a non-zero target.
- R11: When `wr_en_o` is low, `wr_data_o` is 0x00; when a flag enable is low, its flag value is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 8 | Opcode |
| mem_i | input | 8 | Memory operand byte |
| acc_i | input | 8 | Accumulator |
| disp_i | input | 8 | Signed branch displacement |
| pc_i | input | 16 | Address of the opcode byte |
| wr_en_o | output | 1 | Write-back strobe |
| wr_data_o | output | 8 | Write-back byte |
| n_en_o | output | 1 | Negative flag update enable |
| n_o | output | 1 | Negative flag value |
| v_en_o | output | 1 | Overflow flag update enable |
| v_o | output | 1 | Overflow flag value |
| z_en_o | output | 1 | Zero flag update enable |
| z_o | output | 1 | Zero flag value |
| br_taken_o | output | 1 | Bit branch taken |
| br_target_o | output | 16 | Next program counter for bit branches |

## Verification
The hardest cases to reach are the arithmetic edges of the branch target: a target that wraps past 0xFFFF, and the most negative displacement reaching back below the opcode address. Directed vectors place the opcode at 0xFFFE with a positive displacement and near 0x0010 with displacement 0x80, with the tested bit set so the branch is taken. The masked operations are steered to an all-zero result and to a result with both top bits set, so every flag value is seen in both states.

// File: rtl/zbit_pkg.sv
// Shared types and constants for the zero-page bit unit.
// Assumes an 8-bit data path and a 16-bit program counter.
package zbit_pkg;
    localparam int ZB_DW   = 8;
    localparam int ZB_AW   = 16;
    localparam int ZB_OPW  = 8;
    localparam int ZB_ILEN = 3;

    typedef enum logic [2:0] {
        ZB_NONE,
        ZB_CLR,
        ZB_SET,
        ZB_BRCLR,
        ZB_BRSET,
        ZB_TCLR,
        ZB_TSET
    } zb_kind_e;
endpackage

// File: rtl/zbit_decode.sv
// Opcode classifier: maps an opcode to an operation kind and a bit index.
// Assumes the bit index sits in opcode bits 6:4 and bit 7 picks polarity.
module zbit_decode
    import zbit_pkg::*;
#(
    parameter int OPW = ZB_OPW,
    parameter int IW  = 3
) (
    input  logic [OPW-1:0] op,
    output zb_kind_e       kind,
    output logic [IW-1:0]  bit_idx
);
    localparam logic [3:0] LO_BIT = 4'h7;
    localparam logic [3:0] LO_BR  = 4'hF;

    logic [3:0] lo;
    logic       pol;

    assign lo      = op[3:0];
    assign pol     = op[7];
    assign bit_idx = op[4 +: IW];

    // Classify the opcode into one of the supported kinds.
    always_comb begin
        kind = ZB_NONE;
        if (lo == LO_BIT) begin
            kind = pol ? ZB_SET : ZB_CLR;
        end else if (lo == LO_BR) begin
            kind = pol ? ZB_BRSET : ZB_BRCLR;
        end else begin
            case (op)
                8'h14, 8'h1C: kind = ZB_TCLR;
                8'h04, 8'h0C: kind = ZB_TSET;
                default:      kind = ZB_NONE;
            endcase
        end
    end
endmodule

// File: rtl/zbit_alu.sv
// Data path: builds the write-back byte, flags and the tested bit.
// Assumes the kind and index come from the decoder in the same cycle.
module zbit_alu
    import zbit_pkg::*;
#(
    parameter int DW = ZB_DW,
    parameter int IW = $clog2(DW)
) (
    input  zb_kind_e      kind,
    input  logic [IW-1:0] bit_idx,
    input  logic [DW-1:0] mem,
    input  logic [DW-1:0] acc,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic          flag_en,
    output logic          n_flag,
    output logic          v_flag,
    output logic          z_flag,
    output logic          test_bit
);
    logic [DW-1:0] mask;

    // One-hot bit mask from the index, one comparator per bit.
    for (genvar g = 0; g < DW; g++) begin : g_mask
        assign mask[g] = (bit_idx == IW'(g));
    end

    assign test_bit = |(mem & mask);

    // Select the write-back value and the flags for each kind.
    always_comb begin
        wr_en   = 1'b0;
        wr_data = '0;
        flag_en = 1'b0;
        case (kind)
            ZB_CLR:  begin wr_en = 1'b1; wr_data = mem & ~mask; end
            ZB_SET:  begin wr_en = 1'b1; wr_data = mem | mask;  end
            ZB_TCLR: begin wr_en = 1'b1; wr_data = mem & ~acc; flag_en = 1'b1; end
            ZB_TSET: begin wr_en = 1'b1; wr_data = mem | acc;  flag_en = 1'b1; end
            default: begin wr_en = 1'b0; wr_data = '0; end
        endcase
    end

    assign n_flag = flag_en & wr_data[DW-1];
    assign v_flag = flag_en & wr_data[DW-2];
    assign z_flag = flag_en & (wr_data == '0);
endmodule

// File: rtl/zbit_branch.sv
// Branch resolver: decides a bit branch and forms its target address.
// Assumes pc is the opcode address and the instruction is ILEN bytes.
module zbit_branch
    import zbit_pkg::*;
#(
    parameter int AW   = ZB_AW,
    parameter int DW   = ZB_DW,
    parameter int ILEN = ZB_ILEN
) (
    input  zb_kind_e      kind,
    input  logic          test_bit,
    input  logic [DW-1:0] disp,
    input  logic [AW-1:0] pc,
    output logic          taken,
    output logic [AW-1:0] target
);
    logic          is_br;
    logic [AW-1:0] next_pc;
    logic [AW-1:0] offs;

    assign is_br   = (kind == ZB_BRCLR) || (kind == ZB_BRSET);
    assign next_pc = pc + AW'(ILEN);
    assign offs    = {{(AW-DW){disp[DW-1]}}, disp};

    // Decide the branch and pick the target.
    always_comb begin
        taken  = 1'b0;
        target = '0;
        if (is_br) begin
            taken  = (kind == ZB_BRSET) ? test_bit : ~test_bit;
            target = taken ? (next_pc + offs) : next_pc;
        end
    end
endmodule

// File: rtl/zbit_unit.sv
// Top of the zero-page bit unit: decode, data path, branch, output register.
// Assumes the caller supplies operands in the same cycle as the opcode;
// results appear one clock later. Reset is synchronous, active low.
module zbit_unit
    import zbit_pkg::*;
#(
    parameter int DW = ZB_DW,
    parameter int AW = ZB_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    op_i,
    input  logic [DW-1:0] mem_i,
    input  logic [DW-1:0] acc_i,
    input  logic [DW-1:0] disp_i,
    input  logic [AW-1:0] pc_i,
    output logic          wr_en_o,
    output logic [DW-1:0] wr_data_o,
    output logic          n_en_o,
    output logic          n_o,
    output logic          v_en_o,
    output logic          v_o,
    output logic          z_en_o,
    output logic          z_o,
    output logic          br_taken_o,
    output logic [AW-1:0] br_target_o
);
    localparam int IW = $clog2(DW);

    zb_kind_e      kind;
    logic [IW-1:0] bit_idx;
    logic          wr_en_c, flag_en_c, n_c, v_c, z_c, test_bit, taken_c;
    logic [DW-1:0] wr_data_c;
    logic [AW-1:0] target_c;

    zbit_decode #(.OPW(8), .IW(IW)) u_dec (
        .op(op_i), .kind(kind), .bit_idx(bit_idx)
    );

    zbit_alu #(.DW(DW), .IW(IW)) u_alu (
        .kind(kind), .bit_idx(bit_idx), .mem(mem_i), .acc(acc_i),
        .wr_en(wr_en_c), .wr_data(wr_data_c), .flag_en(flag_en_c),
        .n_flag(n_c), .v_flag(v_c), .z_flag(z_c), .test_bit(test_bit)
    );

    zbit_branch #(.AW(AW), .DW(DW), .ILEN(ZB_ILEN)) u_br (
        .kind(kind), .test_bit(test_bit), .disp(disp_i), .pc(pc_i),
        .taken(taken_c), .target(target_c)
    );

    // Register all results; clear them under reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en_o     <= 1'b0;
            wr_data_o   <= '0;
            n_en_o      <= 1'b0;
            n_o         <= 1'b0;
            v_en_o      <= 1'b0;
            v_o         <= 1'b0;
            z_en_o      <= 1'b0;
            z_o         <= 1'b0;
            br_taken_o  <= 1'b0;
            br_target_o <= '0;
        end else begin
            wr_en_o     <= wr_en_c;
            wr_data_o   <= wr_data_c;
            n_en_o      <= flag_en_c;
            n_o         <= n_c;
            v_en_o      <= flag_en_c;
            v_o         <= v_c;
            z_en_o      <= flag_en_c;
            z_o         <= z_c;
            br_taken_o  <= taken_c;
            br_target_o <= target_c;
        end
    end

    AST_BR_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken_o |-> (!wr_en_o && !n_en_o && !z_en_o)); // R5
    AST_BR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        br_taken_o |-> ($past(op_i[3:0]) == 4'hF)); // R5
    AST_WR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> ($past(op_i[3:0]) inside {4'h7, 4'h4, 4'hC})); // R3
    AST_FLAG_NEEDS_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (n_en_o || v_en_o || z_en_o) |-> wr_en_o); // R9
    AST_Z_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        z_en_o |-> (z_o == (wr_data_o == '0))); // R9
    AST_NV_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        n_en_o |-> (n_o == wr_data_o[DW-1] && v_o == wr_data_o[DW-2])); // R9
    AST_IDLE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_o |-> (wr_data_o == '0)); // R11
    AST_RESET_CLEAR: assert property (@(posedge clk)
        !$past(rst_n) |-> (!wr_en_o && !br_taken_o && br_target_o == '0)); // R1
endmodule

// File: tb/tb_zbit_unit.sv
module tb_zbit_unit;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  op_i, mem_i, acc_i, disp_i;
    logic [15:0] pc_i;
    logic        wr_en_o, n_en_o, n_o, v_en_o, v_o, z_en_o, z_o, br_taken_o;
    logic [7:0]  wr_data_o;
    logic [15:0] br_target_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    zbit_unit dut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .mem_i(mem_i), .acc_i(acc_i),
        .disp_i(disp_i), .pc_i(pc_i), .wr_en_o(wr_en_o), .wr_data_o(wr_data_o),
        .n_en_o(n_en_o), .n_o(n_o), .v_en_o(v_en_o), .v_o(v_o),
        .z_en_o(z_en_o), .z_o(z_o), .br_taken_o(br_taken_o),
        .br_target_o(br_target_o)
    );

    // Stimulus table: {op, mem, acc, disp, pc}
    localparam int NV = 16;
    localparam logic [47:0] VEC [0:NV-1] = '{
        {8'h07, 8'hFF, 8'h00, 8'h00, 16'h1000},
        {8'h37, 8'hA8, 8'h00, 8'h00, 16'h1000},
        {8'h77, 8'h80, 8'h00, 8'h00, 16'h1000},
        {8'h87, 8'h00, 8'h00, 8'h00, 16'h2000},
        {8'hD7, 8'h0F, 8'h00, 8'h00, 16'h2000},
        {8'h2F, 8'hFB, 8'h00, 8'h10, 16'h3000},
        {8'h2F, 8'h04, 8'h00, 8'h10, 16'h3000},
        {8'hCF, 8'h10, 8'h00, 8'hF0, 16'h4000},
        {8'hCF, 8'hEF, 8'h00, 8'hF0, 16'h4000},
        {8'h14, 8'hF3, 8'h31, 8'h00, 16'h0000},
        {8'h1C, 8'h55, 8'hFF, 8'h00, 16'h0000},
        {8'h04, 8'h01, 8'h40, 8'h00, 16'h0000},
        {8'h0C, 8'h00, 8'h00, 8'h00, 16'h0000},
        {8'hEA, 8'hFF, 8'hFF, 8'h7F, 16'h5000},
        {8'h0E, 8'hFF, 8'hFF, 8'h7F, 16'h5000},
        {8'h24, 8'h80, 8'h80, 8'h00, 16'h5000}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    task automatic expect_and_check(input logic [7:0] op, input logic [7:0] m,
                                    input logic [7:0] a, input logic [7:0] d,
                                    input logic [15:0] pc);
        logic [3:0]  hi, lo;
        logic [7:0]  bm, res;
        logic        we, fe, tk, isbr;
        logic [15:0] tg;
        hi = op[7:4]; lo = op[3:0];
        bm = 8'h01 << hi[2:0];
        we = 1'b0; fe = 1'b0; tk = 1'b0; isbr = 1'b0; res = 8'h00; tg = 16'h0000;
        if (lo == 4'h7) begin
            we = 1'b1;
            res = hi[3] ? (m | bm) : (m & ~bm);
        end else if (lo == 4'hF) begin
            isbr = 1'b1;
            tk = hi[3] ? ((m & bm) != 0) : ((m & bm) == 0);
            tg = pc + 16'd3 + (tk ? {{8{d[7]}}, d} : 16'h0000);
        end else if (op == 8'h14 || op == 8'h1C) begin
            we = 1'b1; fe = 1'b1; res = m & ~a;
        end else if (op == 8'h04 || op == 8'h0C) begin
            we = 1'b1; fe = 1'b1; res = m | a;
        end
        chk(isbr ? "R5 branch no write" : (fe ? "R8 write enable" : (we ? "R3/R4 write enable" : "R10 idle write")),
            {31'd0, wr_en_o}, {31'd0, we});
        chk(fe ? "R8 write data" : (we ? (hi[3] ? "R4 set data" : "R3 clear data") : "R11 idle data"),
            {24'd0, wr_data_o}, {24'd0, res});
        chk(fe ? "R9 flags" : "R11 flags off",
            {26'd0, n_en_o, n_o, v_en_o, v_o, z_en_o, z_o},
            {26'd0, fe, fe & res[7], fe, fe & res[6], fe, fe & (res == 8'h00)});
        chk(isbr ? "R5 taken" : "R10 no branch", {31'd0, br_taken_o}, {31'd0, tk});
        chk(isbr ? (tk ? "R6 target" : "R7 fallthrough") : "R10 target zero",
            {16'd0, br_target_o}, {16'd0, tg});
    endtask

    task automatic apply(input logic [7:0] op, input logic [7:0] m, input logic [7:0] a,
                         input logic [7:0] d, input logic [15:0] pc);
        @(negedge clk);
        op_i = op; mem_i = m; acc_i = a; disp_i = d; pc_i = pc;
        @(negedge clk);
        expect_and_check(op, m, a, d, pc);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        op_i = 8'h07; mem_i = 8'hFF; acc_i = 8'hFF; disp_i = 8'h00; pc_i = 16'h0000;
        repeat (3) @(negedge clk);
        // R1: reset state while a writing opcode is presented
        chk("R1 reset wr_en", {31'd0, wr_en_o}, 32'd0);
        chk("R1 reset data/flags", {16'd0, wr_data_o, 2'd0, n_en_o, n_o, v_en_o, v_o, z_en_o, z_o},
            32'd0);
        chk("R1 reset branch", {15'd0, br_taken_o, br_target_o}, 32'd0);
        op_i = 8'h00;
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][47:40], VEC[i][39:32], VEC[i][31:24], VEC[i][23:16], VEC[i][15:0]);
        end

        // R6: target wraps past 0xFFFF
        apply(8'hFF, 8'h80, 8'h00, 8'h05, 16'hFFFE);
        chk("R6 wrap target", {16'd0, br_target_o}, 32'h0006);
        // R6: most negative displacement
        apply(8'h8F, 8'h01, 8'h00, 8'h80, 16'h0010);
        chk("R6 negative target", {16'd0, br_target_o}, 32'h0000FF93);
        // R7: not taken fallthrough wraps
        apply(8'h8F, 8'h00, 8'h00, 8'h80, 16'hFFFF);
        chk("R7 fallthrough wrap", {16'd0, br_target_o}, 32'h0002);
        // R9: test-and-clear giving zero
        apply(8'h14, 8'h0F, 8'hFF, 8'h00, 16'h0000);
        chk("R9 zero result flags", {29'd0, n_o, v_o, z_o}, 32'd1);
        // R9: test-and-set with both top bits
        apply(8'h0C, 8'h00, 8'hC0, 8'h00, 16'h0000);
        chk("R9 top bits flags", {21'd0, wr_data_o, n_o, v_o, z_o}, {21'd0, 8'hC0, 3'b110});

        // R2: output follows input one edge later
        @(negedge clk);
        op_i = 8'h87; mem_i = 8'h00; acc_i = 8'h00; disp_i = 8'h00; pc_i = 16'h0000;
        @(posedge clk);
        #1;
        chk("R2 registered after one edge", {24'd0, wr_data_o}, 32'h01);
        op_i = 8'h97;
        #0.5;
        chk("R2 stable between edges", {24'd0, wr_data_o}, 32'h01);

        // R1: reset again clears a held branch result
        @(negedge clk);
        op_i = 8'h0F; mem_i = 8'h00; disp_i = 8'h10; pc_i = 16'h1234;
        @(negedge clk);
        chk("R5 taken before reset", {31'd0, br_taken_o}, 32'd1);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset clears branch", {15'd0, br_taken_o, br_target_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule